// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers sixteen peripheral request lines plus one non-maskable line and presents a single interrupt output to a processor. Two identical eight-line stages are instantiated inside the top. The primary stage owns lines 0 to 7. The secondary stage owns lines 8 to 15 and reports into primary line 2, which is reserved for that purpose. Each maskable line is latched on its rising edge and can be blocked by a per-line mask bit. Line number sets priority, with lower numbers winning. An in-service register in each stage lets a more urgent request interrupt a handler that is already running.

The processor answers the interrupt output with a one-cycle acknowledge pulse. The controller then moves the winning request into service and reports its vector number for one cycle. Software ends each handler by writing an end-of-interrupt code to the command register of a stage. A handler for a secondary line needs that write to the secondary and then to the primary. Register access uses a plain synchronous write strobe and a combinational read path.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is asserted, every pending and in-service bit clears and every mask bit of both stages sets to 1. After reset, `int_out` and `vec_valid` are low.
- R2: A maskable line raises one request on each 0-to-1 transition. Holding the line high adds no further request until it falls and rises again.
- R3: A line whose mask bit is 1 keeps its request pending and does not raise `int_out`. Clearing the mask bit releases the request.
- R4: A rising edge on `nmi` raises `int_out` whatever the masks hold, and it outranks every maskable request. Acknowledging it returns vector 16 and sets no in-service bit.
- R5: When several unmasked requests are pending, the lowest line number is served first.
- R6: An `ack` pulse moves the winning request from pending to in-service. In the following cycle `vec_valid` is high for exactly one cycle, and `vec_num` carries the line number (0-15). An `ack` with no request to serve produces no `vec_valid`.
- R7: A request of higher priority than the most urgent in-service line raises `int_out` again. A request of equal or lower priority waits until that in-service bit clears.
- R8: Writing 0x20 to the command register (offset 0) of a stage clears that stage's lowest-numbered in-service bit. Any other value written there changes nothing.
- R9: A request on secondary line k (0-7) returns vector 8+k and also sets primary in-service bit 2. Until both stages receive an end-of-interrupt, primary line 2 and every lower-priority line stay blocked. The external input bit 2 is ignored.
- R10: Address bit 2 selects the stage (0 primary, 1 secondary). Offset 0 is the command register and reads as 0. Offset 1 is the mask (read/write). Offset 2 is in-service and offset 3 is pending, both read-only. Bit i of each register corresponds to line i of the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Maskable request lines; bit 2 is reserved and ignored |
| nmi | input | 1 | Non-maskable request line, rising-edge sensitive |
| ack | input | 1 | Interrupt acknowledge pulse from the processor |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: bit 2 selects the stage, bits 1:0 the register |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking a delivered vector |
| vec_num | output | 5 | Vector number: 0-15 for lines, 16 for the non-maskable request |

## Verification
The assertions check the following on every cycle:
- The output is quiet right after reset.
- A vector strobe appears only after an acknowledge, and a non-maskable take always returns vector 16.
- A pending non-maskable request always drives the output.
- The output from maskable lines always traces back to an unmasked pending bit.
- Each primary acknowledge adds exactly one in-service bit, and each end-of-interrupt removes exactly one.

Some behaviours need a sequence of events, so only the bench scenarios can show them. These are the ordering of vectors under simultaneous requests, the blocking of equal and lower priorities during nesting, the two-stage end-of-interrupt on the cascade, the single request from a held line, and the effect of a wrong command code.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    localparam int MAX_LINES = 32;
    localparam int PICK_W    = 5;
    localparam logic [7:0] EOI_CMD = 8'h20;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MASK = 2'd1,
        REG_ISR  = 2'd2,
        REG_PEND = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                found;
        logic [PICK_W-1:0]   idx;
    } pick_t;

    typedef struct packed {
        logic take;
        logic eoi;
        logic mask_we;
    } stage_ctl_t;

    // Lowest set bit wins: lower line number means higher priority.
    function automatic pick_t pick_lowest(input logic [MAX_LINES-1:0] v);
        pick_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = PICK_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/nirq_edge_latch.sv
module nirq_edge_latch
    import nirq_pkg::*;
#(
    parameter int                    W         = 8,
    parameter logic [MAX_LINES-1:0]  LEVEL_MAP = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        if (LEVEL_MAP[g]) begin : g_level
            // Sampled each cycle; a take forces one cycle of zero while
            // the upstream source withdraws its request.
            logic lvl_q;
            always_ff @(posedge clk) begin
                if (rst) lvl_q <= 1'b0;
                else     lvl_q <= line[g] & ~clr[g];
            end
            assign pend[g] = lvl_q;
        end else begin : g_edge
            logic prev_q;
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= line[g];
                    pend_q <= (pend_q & ~clr[g]) | (line[g] & ~prev_q);
                end
            end
            assign pend[g] = pend_q;
        end
    end

endmodule

// File: rtl/nirq_stage.sv
module nirq_stage
    import nirq_pkg::*;
#(
    parameter int                   N         = 8,
    parameter logic [MAX_LINES-1:0] LEVEL_MAP = '0,
    localparam int                  IDX_W     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     lines,
    input  stage_ctl_t       ctl,
    input  logic [N-1:0]     mask_d,
    output logic [N-1:0]     mask_q,
    output logic [N-1:0]     pend_q,
    output logic [N-1:0]     isr_q,
    output logic             req,
    output logic [IDX_W-1:0] idx
);

    pick_t        cand;
    pick_t        top_srv;
    logic [N-1:0] grant_oh;
    logic [N-1:0] eoi_oh;

    always_comb begin
        cand    = pick_lowest(MAX_LINES'(pend_q & ~mask_q));
        top_srv = pick_lowest(MAX_LINES'(isr_q));
        req     = cand.found && (!top_srv.found || (cand.idx < top_srv.idx));
        grant_oh = (ctl.take && req)        ? (N'(1) << cand.idx)    : '0;
        eoi_oh   = (ctl.eoi && top_srv.found) ? (N'(1) << top_srv.idx) : '0;
        idx     = cand.idx[IDX_W-1:0];
    end

    nirq_edge_latch #(.W(N), .LEVEL_MAP(LEVEL_MAP)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .line (lines),
        .clr  (grant_oh),
        .pend (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            isr_q  <= '0;
        end else begin
            if (ctl.mask_we) mask_q <= mask_d;
            isr_q <= (isr_q & ~eoi_oh) | grant_oh;
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int          LINES     = 8,
    parameter int          CASC_LINE = 2,
    parameter logic [7:0]  EOI_CODE  = EOI_CMD,
    localparam int         TOTAL     = 2 * LINES,
    localparam int         VEC_W     = $clog2(TOTAL + 1),
    localparam int         IDX_W     = $clog2(LINES),
    localparam int         STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOTAL-1:0] irq_lines,
    input  logic             nmi,
    input  logic             ack,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    output logic             int_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num
);

    localparam int NMI_VEC = TOTAL;

    logic [LINES-1:0] st_lines [STAGES];
    logic [LINES-1:0] st_mask  [STAGES];
    logic [LINES-1:0] st_pend  [STAGES];
    logic [LINES-1:0] st_isr   [STAGES];
    logic             st_req   [STAGES];
    logic [IDX_W-1:0] st_idx   [STAGES];
    stage_ctl_t       st_ctl   [STAGES];

    logic nmi_pend;
    logic nmi_clr;
    logic p_take;
    logic s_take;
    logic eoi_hit;
    logic unused_rsvd;

    assign unused_rsvd = irq_lines[CASC_LINE];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            st_lines[0][i] = (i == CASC_LINE) ? st_req[1] : irq_lines[i];
        end
        st_lines[1] = irq_lines[TOTAL-1:LINES];

        nmi_clr = ack && nmi_pend;
        p_take  = ack && !nmi_pend && st_req[0];
        s_take  = p_take && (st_idx[0] == IDX_W'(CASC_LINE));
        eoi_hit = wr_en && (addr[1:0] == REG_CMD) && (wdata == EOI_CODE);

        for (int s = 0; s < STAGES; s++) begin
            st_ctl[s].take    = (s == 0) ? p_take : s_take;
            st_ctl[s].eoi     = eoi_hit && (addr[2] == s[0]);
            st_ctl[s].mask_we = wr_en && (addr[1:0] == REG_MASK) && (addr[2] == s[0]);
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        nirq_stage #(
            .N         (LINES),
            .LEVEL_MAP ((s == 0) ? (MAX_LINES'(1) << CASC_LINE) : '0)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .lines  (st_lines[s]),
            .ctl    (st_ctl[s]),
            .mask_d (wdata),
            .mask_q (st_mask[s]),
            .pend_q (st_pend[s]),
            .isr_q  (st_isr[s]),
            .req    (st_req[s]),
            .idx    (st_idx[s])
        );
    end

    nirq_edge_latch #(.W(1), .LEVEL_MAP('0)) u_nmi (
        .clk  (clk),
        .rst  (rst),
        .line (nmi),
        .clr  (nmi_clr),
        .pend (nmi_pend)
    );

    assign int_out = nmi_pend || st_req[0];

    always_comb begin
        case (reg_sel_e'(addr[1:0]))
            REG_MASK: rdata = st_mask[addr[2]];
            REG_ISR:  rdata = st_isr[addr[2]];
            REG_PEND: rdata = st_pend[addr[2]];
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_num   <= '0;
        end else begin
            vec_valid <= nmi_clr || p_take;
            if (nmi_clr)     vec_num <= VEC_W'(NMI_VEC);
            else if (s_take) vec_num <= VEC_W'(LINES) + VEC_W'(st_idx[1]);
            else if (p_take) vec_num <= VEC_W'(st_idx[0]);
        end
    end

endmodule

// File: rtl/nirq_checker.sv
module nirq_checker #(
    parameter int LINES = 8,
    parameter int VEC_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             int_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_num,
    input logic             nmi_pend,
    input logic [LINES-1:0] p_isr,
    input logic [LINES-1:0] p_pend,
    input logic [LINES-1:0] p_mask,
    input logic             p_take,
    input logic             p_eoi
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!int_out && !vec_valid));

    p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack));

    p_nmi_vector_r4: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && $past(nmi_pend)) |-> (vec_num == VEC_W'(2 * LINES)));

    p_nmi_drives_out_r4: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> int_out);

    p_mask_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (int_out && !nmi_pend) |-> (|(p_pend & ~p_mask)));

    p_take_adds_one_r6: assert property (@(posedge clk) disable iff (rst)
        (p_take && !p_eoi) |=> ($countones(p_isr) == $countones($past(p_isr)) + 1));

    p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (rst)
        (p_eoi && !p_take && (|p_isr)) |=> ($countones(p_isr) + 1 == $countones($past(p_isr))));

endmodule

bind nest_irq_ctrl nirq_checker #(.LINES(LINES), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_num   (vec_num),
    .nmi_pend  (nmi_pend),
    .p_isr     (st_isr[0]),
    .p_pend    (st_pend[0]),
    .p_mask    (st_mask[0]),
    .p_take    (p_take),
    .p_eoi     (st_ctl[0].eoi)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq = '0;
    logic        nmi = 1'b0;
    logic        ack = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        int_out;
    logic        vec_valid;
    logic [4:0]  vec_num;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_lines(irq), .nmi(nmi), .ack(ack),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .int_out(int_out), .vec_valid(vec_valid), .vec_num(vec_num)
    );

    // Stimulus table: line raised, vector expected.
    localparam int NV = 7;
    localparam logic [4:0] VT_LINE [NV] = '{5'd0, 5'd1, 5'd3, 5'd7, 5'd8, 5'd12, 5'd15};
    localparam logic [4:0] VT_EXP  [NV] = '{5'd0, 5'd1, 5'd3, 5'd7, 5'd8, 5'd12, 5'd15};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic ack_expect(input string req, input logic [4:0] exp);
        logic vv;
        logic [4:0] vn;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        vv = vec_valid;
        vn = vec_num;
        chk({req, " vec_valid"}, {31'd0, vv}, 32'd1);
        chk({req, " vec_num"}, {27'd0, vn}, {27'd0, exp});
        @(negedge clk);
        chk({req, " strobe one cycle"}, {31'd0, vec_valid}, 32'd0);
    endtask

    task automatic eoi(input logic stage);
        wr({stage, 2'd0}, 8'h20);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state, R10 register layout
        chk("R1 int_out", {31'd0, int_out}, 32'd0);
        chk("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
        rd_chk("R1 primary mask", 3'd1, 8'hFF);
        rd_chk("R1 secondary mask", 3'd5, 8'hFF);
        rd_chk("R1 primary isr", 3'd2, 8'h00);
        rd_chk("R1 primary pend", 3'd3, 8'h00);
        rd_chk("R10 cmd reads zero", 3'd0, 8'h00);

        // R4 non-maskable while every mask is set
        nmi = 1'b1;
        wait_cyc(2);
        chk("R4 nmi ignores mask", {31'd0, int_out}, 32'd1);
        ack_expect("R4 nmi vector", 5'd16);
        chk("R4 nmi served", {31'd0, int_out}, 32'd0);
        rd_chk("R4 no in-service", 3'd2, 8'h00);
        nmi = 1'b0;

        wr(3'd1, 8'h00);
        wr(3'd5, 8'h00);
        rd_chk("R10 mask write", 3'd1, 8'h00);

        // R6/R9 table walk
        for (int k = 0; k < NV; k++) begin
            irq[VT_LINE[k]] = 1'b1;
            wait_cyc(3);
            chk("R6 request raises int", {31'd0, int_out}, 32'd1);
            irq[VT_LINE[k]] = 1'b0;
            ack_expect("R6 table vector", VT_EXP[k]);
            chk("R6 int drops after take", {31'd0, int_out}, 32'd0);
            if (VT_LINE[k] >= 8) begin
                rd_chk("R9 primary holds line 2", 3'd2, 8'h04);
                eoi(1'b1);
            end
            eoi(1'b0);
            rd_chk("R8 primary isr clear", 3'd2, 8'h00);
        end

        // R6 ack with nothing pending
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R6 spurious ack", {31'd0, vec_valid}, 32'd0);

        // R4 nmi outranks line 0
        irq[0] = 1'b1; nmi = 1'b1;
        wait_cyc(2);
        ack_expect("R4 nmi first", 5'd16);
        ack_expect("R5 line 0 after nmi", 5'd0);
        eoi(1'b0);
        irq[0] = 1'b0; nmi = 1'b0;

        // R5 simultaneous requests, R7 lower waits
        irq[5] = 1'b1; irq[1] = 1'b1;
        wait_cyc(2);
        ack_expect("R5 lowest first", 5'd1);
        chk("R7 lower waits", {31'd0, int_out}, 32'd0);
        eoi(1'b0);
        chk("R7 released after eoi", {31'd0, int_out}, 32'd1);
        ack_expect("R5 then line 5", 5'd5);
        eoi(1'b0);
        irq[5] = 1'b0; irq[1] = 1'b0;
        wait_cyc(1);

        // R7 nesting
        irq[5] = 1'b1;
        wait_cyc(2);
        ack_expect("R7 first handler", 5'd5);
        irq[5] = 1'b0; irq[6] = 1'b1;
        wait_cyc(2);
        chk("R7 lower blocked", {31'd0, int_out}, 32'd0);
        irq[5] = 1'b1;
        wait_cyc(2);
        chk("R7 equal blocked", {31'd0, int_out}, 32'd0);
        irq[1] = 1'b1;
        wait_cyc(2);
        chk("R7 higher preempts", {31'd0, int_out}, 32'd1);
        ack_expect("R7 nested vector", 5'd1);
        rd_chk("R7 two in service", 3'd2, 8'h22);
        eoi(1'b0);
        rd_chk("R8 clears most urgent", 3'd2, 8'h20);
        chk("R7 still blocked", {31'd0, int_out}, 32'd0);
        eoi(1'b0);
        ack_expect("R7 equal served later", 5'd5);
        eoi(1'b0);
        ack_expect("R7 lower served last", 5'd6);
        eoi(1'b0);
        irq[1] = 1'b0; irq[5] = 1'b0; irq[6] = 1'b0;
        wait_cyc(1);

        // R8 wrong command code
        irq[3] = 1'b1;
        wait_cyc(2);
        ack_expect("R8 setup", 5'd3);
        wr(3'd0, 8'h21);
        rd_chk("R8 other code ignored", 3'd2, 8'h08);
        eoi(1'b0);
        rd_chk("R8 eoi clears", 3'd2, 8'h00);
        irq[3] = 1'b0;
        wait_cyc(1);

        // R3 mask
        wr(3'd1, 8'h08);
        irq[3] = 1'b1;
        wait_cyc(2);
        chk("R3 masked no int", {31'd0, int_out}, 32'd0);
        rd_chk("R3 still pending", 3'd3, 8'h08);
        wr(3'd1, 8'h00);
        chk("R3 unmask releases", {31'd0, int_out}, 32'd1);
        ack_expect("R3 vector", 5'd3);
        eoi(1'b0);
        irq[3] = 1'b0;
        wait_cyc(1);

        // R2 held line
        irq[4] = 1'b1;
        wait_cyc(2);
        ack_expect("R2 first edge", 5'd4);
        eoi(1'b0);
        wait_cyc(3);
        chk("R2 held line no repeat", {31'd0, int_out}, 32'd0);
        rd_chk("R2 nothing pending", 3'd3, 8'h00);
        irq[4] = 1'b0;
        wait_cyc(1);
        irq[4] = 1'b1;
        wait_cyc(2);
        chk("R2 new edge", {31'd0, int_out}, 32'd1);
        ack_expect("R2 second vector", 5'd4);
        eoi(1'b0);
        irq[4] = 1'b0;
        wait_cyc(1);

        // R9 cascade needs eoi on both stages
        irq[12] = 1'b1;
        wait_cyc(3);
        ack_expect("R9 secondary vector", 5'd12);
        irq[12] = 1'b0;
        eoi(1'b1);
        rd_chk("R9 secondary cleared", 3'd6, 8'h00);
        rd_chk("R9 primary still holds", 3'd2, 8'h04);
        irq[10] = 1'b1; irq[4] = 1'b1;
        wait_cyc(3);
        chk("R9 cascade blocked", {31'd0, int_out}, 32'd0);
        irq[0] = 1'b1;
        wait_cyc(2);
        ack_expect("R9 line 0 preempts", 5'd0);
        eoi(1'b0);
        rd_chk("R9 line 2 remains", 3'd2, 8'h04);
        eoi(1'b0);
        wait_cyc(2);
        ack_expect("R9 second secondary", 5'd10);
        eoi(1'b1);
        eoi(1'b0);
        wait_cyc(1);
        ack_expect("R9 line 4 after cascade", 5'd4);
        eoi(1'b0);
        irq[10] = 1'b0; irq[4] = 1'b0; irq[0] = 1'b0;
        wait_cyc(2);

        // R9 reserved input ignored
        irq[2] = 1'b1;
        wait_cyc(3);
        chk("R9 reserved input ignored", {31'd0, int_out}, 32'd0);
        rd_chk("R9 reserved not pending", 3'd3, 8'h00);
        irq[2] = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule